// File: doc/BRIEF.md
# Display Scan Line Address Generator

This block produces the memory line address that the panel refresh logic reads while it drives the common outputs one after another. A start-line register chooses which memory line appears on the first common output, so software can scroll the picture vertically or switch between pages without rewriting memory. A line counter advances once per common period and restarts whenever the frame signal changes level. The block adds the start line to the counter modulo 64 to address the 64 main commons. After the last main common it selects the separate icon line, which never takes part in the wrap and can never be chosen as the start line.

A new start line is held as pending and is copied into the active register only at the next frame change, so a frame always shows one start line from top to bottom. The block also applies normal or inverse pixel polarity to each fetched data byte.

The counter is a two-state machine. `SCAN` walks the main commons and `ICON` holds the icon line. The transitions are:

- `SCAN -> ICON`: a common strobe while the counter is on line index 63.
- `ICON -> ICON`: saturation. Further strobes change nothing.
- `any -> SCAN`: a frame level change, which also clears the counter to 0.

Top module: `scan_line_gen`

## Requirements
- R1: After reset `line_addr` is 0, `icon_sel` is 0, and both the pending and the active start line are 0.
- R2: During common index k (k = 0..63), `line_addr` equals (active start + k) mod 64 and `icon_sel` is 0.
- R3: Each cycle with `com_strobe` high and no frame change advances the common index by one. The new address is visible in the cycle after the strobe.
- R4: Any change of the `frame_lvl` level clears the common index to 0 in the next cycle. This takes priority over a strobe in the same cycle.
- R5: The 64th strobe after a frame change enters the icon state: `icon_sel` becomes 1 and `line_addr` is 0.
- R6: In the icon state, further strobes keep `icon_sel` at 1 until the next frame change, which returns the block to `SCAN` at index 0.
- R7: A start-line write (`start_wr` high) with `start_val` of 64 or more is ignored, and the previous pending value is kept.
- R8: A valid start-line write has no effect on `line_addr` until the next frame change, when it becomes the active start.
- R9: `pix_out` equals `pix_in` when `inverse_en` is 0 and equals its bitwise complement when `inverse_en` is 1, so a stored 1 gives an off pixel in inverse mode.
- R10: The address wraps: with start 60, common index 3 gives 63 and common index 4 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_lvl | input | 1 | Frame signal; every level change starts a frame |
| com_strobe | input | 1 | One-cycle pulse per common period |
| start_wr | input | 1 | Start-line write enable |
| start_val | input | 7 | Start line to write; values of 64 or more are rejected |
| inverse_en | input | 1 | 1 selects inverse pixel polarity |
| pix_in | input | 8 | Fetched display data byte |
| line_addr | output | 6 | Memory line address for the current main common |
| icon_sel | output | 1 | High while the icon line is selected |
| pix_out | output | 8 | Data byte after the polarity is applied |

## Verification
The hardest condition to reach is the saturated icon state. Testing it needs 64 strobes with no frame change, followed by more strobes to show that the counter does not wrap back into the main lines. The bench gets there with a task that issues a counted run of strobes and then adds extra strobes. It also lines up a frame change and a strobe in the same cycle, so that the priority between clearing the counter and advancing it can be observed at `line_addr`.

// File: rtl/scan_line_pkg.sv
package scan_line_pkg;
    localparam int MAIN_LINES = 64;
    localparam int LINE_W     = $clog2(MAIN_LINES);
    localparam int START_W    = LINE_W + 1;

    typedef enum logic {
        SCAN = 1'b0,
        ICON = 1'b1
    } scan_state_t;
endpackage

// File: rtl/start_line_reg.sv
module start_line_reg
    import scan_line_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [START_W-1:0] val,
    input  logic               frame_edge,
    output logic [LINE_W-1:0]  active
);
    logic [LINE_W-1:0] pending;
    logic              in_range;

    assign in_range = (val < START_W'(MAIN_LINES));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            active  <= '0;
        end else begin
            if (wr && in_range) begin
                pending <= val[LINE_W-1:0];
            end
            if (frame_edge) begin
                active <= pending;
            end
        end
    end

    assert_reject_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && val >= START_W'(MAIN_LINES)) |=> $stable(pending));

    assert_hold_midframe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_edge |=> $stable(active));
endmodule

// File: rtl/line_counter.sv
module line_counter
    import scan_line_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_edge,
    input  logic              strobe,
    output scan_state_t       state,
    output logic [LINE_W-1:0] idx
);
    scan_state_t       state_nx;
    logic [LINE_W-1:0] idx_nx;
    logic              last_main;

    assign last_main = (idx == LINE_W'(MAIN_LINES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SCAN;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        if (frame_edge) begin
            state_nx = SCAN;
            idx_nx   = '0;
        end else begin
            unique case (state)
                SCAN: if (strobe) begin
                    if (last_main) state_nx = ICON;
                    else           idx_nx   = idx + 1'b1;
                end
                ICON: state_nx = ICON;
                default: state_nx = SCAN;
            endcase
        end
    end

    assert_clear_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |=> (state == SCAN && idx == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !frame_edge && state == SCAN && !last_main)
            |=> idx == $past(idx) + 1'b1);

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ICON && !frame_edge) |=> state == ICON);
endmodule

// File: rtl/pixel_polarity.sv
module pixel_polarity #(
    parameter int PIX_W = 8
) (
    input  logic             inverse,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] dout
);
    for (genvar b = 0; b < PIX_W; b++) begin : g_bit
        assign dout[b] = din[b] ^ inverse;
    end
endmodule

// File: rtl/scan_line_gen.sv
module scan_line_gen
    import scan_line_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_lvl,
    input  logic               com_strobe,
    input  logic               start_wr,
    input  logic [START_W-1:0] start_val,
    input  logic               inverse_en,
    input  logic [PIX_W-1:0]   pix_in,
    output logic [LINE_W-1:0]  line_addr,
    output logic               icon_sel,
    output logic [PIX_W-1:0]   pix_out
);
    logic              frame_q;
    logic              frame_edge;
    logic [LINE_W-1:0] start_act;
    logic [LINE_W-1:0] idx;
    scan_state_t       state;

    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= 1'b0;
        else        frame_q <= frame_lvl;
    end
    assign frame_edge = rst_n && (frame_lvl != frame_q);

    start_line_reg u_start (
        .clk(clk), .rst_n(rst_n), .wr(start_wr), .val(start_val),
        .frame_edge(frame_edge), .active(start_act)
    );

    line_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .frame_edge(frame_edge),
        .strobe(com_strobe), .state(state), .idx(idx)
    );

    pixel_polarity #(.PIX_W(PIX_W)) u_pol (
        .inverse(inverse_en), .din(pix_in), .dout(pix_out)
    );

    always_comb begin
        unique case (state)
            SCAN: begin
                line_addr = start_act + idx;
                icon_sel  = 1'b0;
            end
            ICON: begin
                line_addr = '0;
                icon_sel  = 1'b1;
            end
            default: begin
                line_addr = '0;
                icon_sel  = 1'b0;
            end
        endcase
    end

    assert_icon_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        icon_sel |-> line_addr == '0);

    assert_frame_exits_icon_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |=> !icon_sel);
endmodule

// File: tb/test_scan_line_gen.sv
module test_scan_line_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_lvl = 1'b0;
    logic       com_strobe = 1'b0;
    logic       start_wr = 1'b0;
    logic [6:0] start_val = '0;
    logic       inverse_en = 1'b0;
    logic [7:0] pix_in = '0;
    logic [5:0] line_addr;
    logic       icon_sel;
    logic [7:0] pix_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    scan_line_gen i_scan_line_gen (
        .clk(clk), .rst_n(rst_n), .frame_lvl(frame_lvl), .com_strobe(com_strobe),
        .start_wr(start_wr), .start_val(start_val), .inverse_en(inverse_en),
        .pix_in(pix_in), .line_addr(line_addr), .icon_sel(icon_sel), .pix_out(pix_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) com_strobe = 1'b1;
            @(negedge clk) com_strobe = 1'b0;
        end
    endtask

    task automatic flip_frame();
        @(negedge clk) frame_lvl = ~frame_lvl;
        @(negedge clk);
    endtask

    task automatic write_start(input int v);
        @(negedge clk) begin start_wr = 1'b1; start_val = 7'(v); end
        @(negedge clk) start_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 addr", line_addr, 0);
        check("R1 icon", icon_sel, 0);
        flip_frame();
        check("R1 start zero", line_addr, 0);
    endtask

    task automatic t_scroll();
        write_start(5);
        strobes(2);
        check("R8 pending not yet active", line_addr, 2);
        flip_frame();
        check("R2 k=0", line_addr, 5);
        strobes(3);
        check("R3 k=3", line_addr, 8);
        check("R2 icon low", icon_sel, 0);
    endtask

    task automatic t_frame_clear();
        strobes(4);
        flip_frame();
        check("R4 cleared", line_addr, 5);
        strobes(2);
        @(negedge clk) begin frame_lvl = ~frame_lvl; com_strobe = 1'b1; end
        @(negedge clk) com_strobe = 1'b0;
        check("R4 frame beats strobe", line_addr, 5);
    endtask

    task automatic t_icon();
        strobes(63);
        check("R5 k=63", line_addr, 4);
        check("R5 not icon yet", icon_sel, 0);
        strobes(1);
        check("R5 icon", icon_sel, 1);
        check("R5 icon addr", line_addr, 0);
        strobes(5);
        check("R6 saturated", icon_sel, 1);
        flip_frame();
        check("R6 exit icon", icon_sel, 0);
        check("R6 back to start", line_addr, 5);
    endtask

    task automatic t_reject();
        write_start(64);
        write_start(127);
        flip_frame();
        check("R7 rejected", line_addr, 5);
    endtask

    task automatic t_wrap();
        write_start(60);
        flip_frame();
        check("R10 k=0", line_addr, 60);
        strobes(3);
        check("R10 k=3", line_addr, 63);
        strobes(1);
        check("R10 k=4", line_addr, 0);
        strobes(6);
        check("R10 k=10", line_addr, 6);
    endtask

    task automatic t_polarity();
        @(negedge clk) begin inverse_en = 1'b0; pix_in = 8'hA5; end
        #1 check("R9 normal", pix_out, 'hA5);
        @(negedge clk) inverse_en = 1'b1;
        #1 check("R9 inverse", pix_out, 'h5A);
        @(negedge clk) pix_in = 8'hFF;
        #1 check("R9 inverse ones", pix_out, 'h00);
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scroll();
        t_frame_clear();
        t_icon();
        t_reject();
        t_wrap();
        t_polarity();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule